// File: doc/BRIEF.md
# Asynchronous Memory Bus Cycle Decoder

This block sits in a fast system clock domain and watches the three active-low control strobes of an asynchronous byte-wide memory bus: chip select, read strobe and write strobe. Each strobe passes through a two-flop synchronizer and a minimum-pulse filter. The filter rejects any level that does not persist for a set number of clock cycles. From the filtered strobes the block registers a cycle code (standby, bus released, read, write or a read/write clash) and a data-driver enable that a pad ring can use to steer the byte-lane drivers.

For writes, the address is captured when the second of chip select and write strobe goes low, which is the point where both are low together. The data is captured when the first of the two returns high, which is the point where that condition ends. If the read strobe is seen low at any point in the window, the write is dropped. A completed write leaves the block as a single-cycle event that carries the captured address and byte. An inactivity timer raises an automatic-standby flag after a set time with no strobe or address movement. Any later movement clears the flag.

Address and data are delayed by exactly the strobe path latency, so that what the capture logic samples lines up with the filtered strobe edges. Pulse widths and the standby interval are given in picoseconds and converted to cycle counts from the clock period.

Top module: `membus_cycle_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cycle_o` is 0, and `dout_en_o`, `wr_evt_o` and `auto_stby_o` are all 0.
- R2: `cycle_o` reports the filtered strobe state with these codes:
  - 0: chip select high (standby).
  - 1: chip select low, read strobe high, write strobe high (bus released).
  - 2: chip select low, read strobe low, write strobe high (read).
  - 3: chip select low, write strobe low, read strobe high (write).
  - 4: all three strobes low (clash).
- R3: `dout_en_o` is 1 only during a read cycle (code 2). It is 0 whenever the read strobe or chip select is high.
- R4: While chip select is high, movement on the other strobes, the address or the data produces no write event and no data drive.
- R5: The write address is the value on `addr_i` when the later of the chip-select and write-strobe falling edges occurs. Address changes after that point have no effect.
- R6: The write data is the value on `data_i` when the earlier of the chip-select and write-strobe rising edges occurs. Data changes after that point have no effect.
- R7: Each accepted write produces exactly one `wr_evt_o` pulse, one clock wide, with `wr_addr_o` and `wr_data_o` valid in that cycle.
- R8: A low pulse on chip select or the write strobe that lasts fewer than FILT_CYC synchronized cycles is ignored and produces no write event. FILT_CYC is MIN_PULSE_PS divided by CLK_PERIOD_PS, rounded up, with a minimum of 1.
- R9: A write during which the read strobe is low at any point is discarded, and no event is produced.
- R10: `auto_stby_o` rises after IDLE_CYC consecutive cycles with no change on the filtered strobes or the address. IDLE_CYC is IDLE_PS divided by CLK_PERIOD_PS, rounded up. The flag clears in the cycle after any change.
- R11: Automatic standby does not stop a read in progress: `dout_en_o` stays 1 while `auto_stby_o` is 1 during a steady read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select strobe, active low, asynchronous |
| oe_n | input | 1 | Read strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus write data |
| cycle_o | output | 3 | Registered cycle code (see R2) |
| dout_en_o | output | 1 | Data driver enable, high during a read |
| wr_evt_o | output | 1 | One-cycle accepted-write pulse |
| wr_addr_o | output | ADDR_W | Address of the last accepted write |
| wr_data_o | output | DATA_W | Data of the last accepted write |
| auto_stby_o | output | 1 | Automatic-standby flag |

## Verification
The bench builds the block with a 10 ns clock period, MIN_PULSE_PS of 30000 and IDLE_PS of 150000, which gives a three-cycle pulse filter and a fifteen-cycle standby interval. With these values, a two-cycle strobe glitch falls inside the rejection window while normal strobes pass. The standby flag can then be seen both before and after its threshold within a short run. The default 5 ns filter would round to a single cycle, so it could not separate a glitch from a real strobe. Both orders of strobe edges are driven, so the address and data capture points can each be checked against later bus changes.

// File: rtl/mbd_pkg.sv
`timescale 1ns/1ps
package mbd_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE  = 3'd0,
    CYC_HIZ   = 3'd1,
    CYC_RD    = 3'd2,
    CYC_WR    = 3'd3,
    CYC_CLASH = 3'd4
  } bus_cyc_e;

  // ceiling division, never below one
  function automatic int ps_to_cyc(input int span_ps, input int clk_ps);
    int n;
    n = (span_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

endpackage

// File: rtl/mbd_strobe_filter.sv
`timescale 1ns/1ps
module mbd_strobe_filter #(
  parameter int FILT_CYC = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic filt_n
);
  localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_CYC - 1);

  logic          sync1_q, sync_q, filt_q;
  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= 1'b1;
      sync_q  <= 1'b1;
    end else begin
      sync1_q <= pin_n;
      sync_q  <= sync1_q;
    end
  end

  // flip only after the new level persisted FILT_CYC cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      filt_q <= 1'b1;
      run_q  <= '0;
    end else if (sync_q == filt_q) begin
      run_q <= '0;
    end else if (run_q == CNT_LAST) begin
      filt_q <= sync_q;
      run_q  <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_n = filt_q;

  // R8: the filtered level only moves after the raw level disagreed
  a_r8_flip_needs_diff: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> $past(sync_q != filt_q));

endmodule

// File: rtl/mbd_delay_line.sv
`timescale 1ns/1ps
module mbd_delay_line #(
  parameter int W     = 8,
  parameter int DEPTH = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [DEPTH-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q <= '0;
    end else begin
      for (int i = DEPTH - 1; i > 0; i--) stg_q[i] <= stg_q[i-1];
      stg_q[0] <= din;
    end
  end

  assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/mbd_cycle_class.sv
`timescale 1ns/1ps
module mbd_cycle_class
  import mbd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ce_f,
  input  logic     oe_f,
  input  logic     we_f,
  output bus_cyc_e cyc_o,
  output logic     dout_en_o
);
  bus_cyc_e cyc_d, cyc_q;
  logic     drv_q;

  always_comb begin
    if (ce_f)              cyc_d = CYC_IDLE;
    else if (!oe_f && we_f) cyc_d = CYC_RD;
    else if (oe_f && !we_f) cyc_d = CYC_WR;
    else if (oe_f && we_f)  cyc_d = CYC_HIZ;
    else                    cyc_d = CYC_CLASH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= CYC_IDLE;
      drv_q <= 1'b0;
    end else begin
      cyc_q <= cyc_d;
      drv_q <= (cyc_d == CYC_RD);
    end
  end

  assign cyc_o     = cyc_q;
  assign dout_en_o = drv_q;

  // R3 / R4: driving needs chip select and read strobe low one cycle earlier
  a_r3_drive_needs_read: assert property (@(posedge clk) disable iff (rst)
    drv_q |-> $past(!ce_f && !oe_f));

endmodule

// File: rtl/mbd_write_capture.sv
`timescale 1ns/1ps
module mbd_write_capture #(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_f,
  input  logic          oe_f,
  input  logic          we_f,
  input  logic [AW-1:0] addr_d,
  input  logic [DW-1:0] data_d,
  output logic          wr_evt_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  logic          wsel;
  logic          wsel_q, spoil_q, evt_q;
  logic [AW-1:0] addr_lat_q, wa_q;
  logic [DW-1:0] wd_q;

  assign wsel = !ce_f && !we_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel_q     <= 1'b0;
      spoil_q    <= 1'b0;
      evt_q      <= 1'b0;
      addr_lat_q <= '0;
      wa_q       <= '0;
      wd_q       <= '0;
    end else begin
      wsel_q <= wsel;
      evt_q  <= 1'b0;
      // later falling edge: both strobes low together for the first time
      if (wsel && !wsel_q) begin
        addr_lat_q <= addr_d;
        spoil_q    <= !oe_f;
      end else if (wsel && !oe_f) begin
        spoil_q <= 1'b1;
      end
      // earlier rising edge: the pair stops being low together
      if (!wsel && wsel_q && !spoil_q && oe_f) begin
        evt_q <= 1'b1;
        wa_q  <= addr_lat_q;
        wd_q  <= data_d;
      end
    end
  end

  assign wr_evt_o  = evt_q;
  assign wr_addr_o = wa_q;
  assign wr_data_o = wd_q;

  // R7: an event never lasts two cycles
  a_r7_evt_one_cycle: assert property (@(posedge clk) disable iff (rst)
    evt_q |=> !evt_q);

  // R9: accepted writes end with the read strobe high
  a_r9_evt_needs_oe_high: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> $past(oe_f));

  // R5: the latched address holds while the write window stays open
  a_r5_addr_held: assert property (@(posedge clk) disable iff (rst)
    (wsel && wsel_q) |=> $stable(addr_lat_q));

endmodule

// File: rtl/mbd_idle_timer.sv
`timescale 1ns/1ps
module mbd_idle_timer #(
  parameter int IDLE_CYC = 15,
  parameter int AW       = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    strb_f,
  input  logic [AW-1:0] addr_d,
  output logic          auto_stby_o
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);

  logic [2:0]    strb_q;
  logic [AW-1:0] addr_q;
  logic [IW-1:0] cnt_q;
  logic          stby_q, act;

  assign act = (strb_f != strb_q) || (addr_d != addr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= 3'b111;
      addr_q <= '0;
      cnt_q  <= '0;
      stby_q <= 1'b0;
    end else begin
      strb_q <= strb_f;
      addr_q <= addr_d;
      if (act) begin
        cnt_q  <= '0;
        stby_q <= 1'b0;
      end else if (!stby_q) begin
        if (cnt_q == IDLE_LAST) begin
          stby_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign auto_stby_o = stby_q;

  // R10: movement clears the flag on the next cycle
  a_r10_clear_on_activity: assert property (@(posedge clk) disable iff (rst)
    act |=> !stby_q);

  // R10: the flag only rises after a quiet cycle
  a_r10_rise_after_quiet: assert property (@(posedge clk) disable iff (rst)
    $rose(stby_q) |-> $past(!act));

endmodule

// File: rtl/membus_cycle_decoder.sv
`timescale 1ns/1ps
module membus_cycle_decoder
  import mbd_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int MIN_PULSE_PS  = 5000,
  parameter int IDLE_PS       = 150000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [2:0]        cycle_o,
  output logic              dout_en_o,
  output logic              wr_evt_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              auto_stby_o
);
  localparam int FILT_CYC = ps_to_cyc(MIN_PULSE_PS, CLK_PERIOD_PS);
  localparam int IDLE_CYC = ps_to_cyc(IDLE_PS, CLK_PERIOD_PS);
  localparam int SYNC_STG = 2;
  localparam int ALIGN    = SYNC_STG + FILT_CYC;

  logic [2:0]        strb_raw, strb_f;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] data_d;
  bus_cyc_e          cyc;

  // bit 2 = chip select, bit 1 = read strobe, bit 0 = write strobe
  assign strb_raw = {ce_n, oe_n, we_n};

  for (genvar g = 0; g < 3; g++) begin : g_strb
    mbd_strobe_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk    (clk),
      .rst    (rst),
      .pin_n  (strb_raw[g]),
      .filt_n (strb_f[g])
    );
  end

  mbd_delay_line #(.W(ADDR_W), .DEPTH(ALIGN)) u_addr_dly (
    .clk(clk), .rst(rst), .din(addr_i), .dout(addr_d)
  );

  mbd_delay_line #(.W(DATA_W), .DEPTH(ALIGN)) u_data_dly (
    .clk(clk), .rst(rst), .din(data_i), .dout(data_d)
  );

  mbd_cycle_class u_class (
    .clk       (clk),
    .rst       (rst),
    .ce_f      (strb_f[2]),
    .oe_f      (strb_f[1]),
    .we_f      (strb_f[0]),
    .cyc_o     (cyc),
    .dout_en_o (dout_en_o)
  );

  mbd_write_capture #(.AW(ADDR_W), .DW(DATA_W)) u_wcap (
    .clk       (clk),
    .rst       (rst),
    .ce_f      (strb_f[2]),
    .oe_f      (strb_f[1]),
    .we_f      (strb_f[0]),
    .addr_d    (addr_d),
    .data_d    (data_d),
    .wr_evt_o  (wr_evt_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );

  mbd_idle_timer #(.IDLE_CYC(IDLE_CYC), .AW(ADDR_W)) u_idle (
    .clk         (clk),
    .rst         (rst),
    .strb_f      (strb_f),
    .addr_d      (addr_d),
    .auto_stby_o (auto_stby_o)
  );

  assign cycle_o = cyc;

  // R4: no write event can follow a cycle classed as standby
  a_r4_no_evt_in_standby: assert property (@(posedge clk) disable iff (rst)
    (cycle_o == 3'd0) |=> !wr_evt_o);

  // R1: outputs quiet in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!wr_evt_o && !dout_en_o && !auto_stby_o && cycle_o == 3'd0));

endmodule

// File: tb/membus_cycle_decoder_tb_top.sv
`timescale 1ns/1ps
module membus_cycle_decoder_tb_top;
  localparam int AW = 17;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [2:0]    cycle_o;
  logic          dout_en_o, wr_evt_o, auto_stby_o;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;

  int total = 0;
  int bad   = 0;
  int evt_seen = 0;
  int evt_pushed = 0;
  bit prev_evt = 1'b0;
  bit done = 1'b0;

  logic [AW+DW-1:0] exp_q[$];
  string            tag_q[$];

  always #5 clk = ~clk;

  membus_cycle_decoder #(
    .ADDR_W(AW), .DATA_W(DW), .CLK_PERIOD_PS(10000),
    .MIN_PULSE_PS(30000), .IDLE_PS(150000)
  ) dut_i (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr_i(addr_i), .data_i(data_i), .cycle_o(cycle_o),
    .dout_en_o(dout_en_o), .wr_evt_o(wr_evt_o), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .auto_stby_o(auto_stby_o)
  );

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req);
    exp_q.push_back({a, d});
    tag_q.push_back(req);
    evt_pushed++;
  endtask

  // monitor: pops the scoreboard on each event
  always @(negedge clk) begin
    if (!rst) begin
      if (wr_evt_o) begin
        evt_seen++;
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R4 unexpected write actual=%0h/%0h expected=none", wr_addr_o, wr_data_o);
        end else begin
          logic [AW+DW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if ({wr_addr_o, wr_data_o} != e) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", t, {wr_addr_o, wr_data_o}, e);
          end
        end
        if (prev_evt) begin
          total++;
          bad++;
          $display("FAIL R7 pulse wider than one cycle actual=2 expected=1");
        end
      end
      prev_evt = wr_evt_o;
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
    end
  end

  initial begin
    cyc(5);
    @(negedge clk);
    check("R1 cycle in reset", cycle_o, 0);
    check("R1 evt in reset", wr_evt_o, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 cycle", cycle_o, 0);
    check("R1 dout_en", dout_en_o, 0);
    check("R1 evt", wr_evt_o, 0);
    check("R1 stby", auto_stby_o, 0);

    // R2 bus released / read / clash
    cyc(2); ce_n = 0; cyc(10); @(negedge clk);
    check("R2 hiz code", cycle_o, 1);
    check("R3 no drive when released", dout_en_o, 0);
    cyc(1); addr_i = 17'h00123; oe_n = 0; cyc(10); @(negedge clk);
    check("R2 read code", cycle_o, 2);
    check("R3 drive in read", dout_en_o, 1);
    // R10/R11: steady read long enough for standby
    cyc(8); @(negedge clk);
    check("R10 not yet standby", auto_stby_o, 0);
    cyc(30); @(negedge clk);
    check("R10 standby after quiet", auto_stby_o, 1);
    check("R11 read still driven", dout_en_o, 1);
    cyc(1); oe_n = 1; cyc(8); @(negedge clk);
    check("R10 cleared by activity", auto_stby_o, 0);
    check("R3 released after read", dout_en_o, 0);
    cyc(1); ce_n = 1; cyc(10);

    // R4: chip select high, other strobes move
    oe_n = 0; cyc(10); @(negedge clk);
    check("R4 cycle standby", cycle_o, 0);
    check("R4 no drive", dout_en_o, 0);
    oe_n = 1; addr_i = 17'h1AAAA; data_i = 8'h55;
    we_n = 0; cyc(10); data_i = 8'h66; we_n = 1; cyc(12);

    // R5: chip select first, address moves before and after write strobe
    addr_i = 17'h00A01; data_i = 8'h3C; ce_n = 0; cyc(8);
    addr_i = 17'h00A02; cyc(8);
    we_n = 0; cyc(4); @(negedge clk);
    cyc(4); @(negedge clk);
    check("R2 write code", cycle_o, 3);
    cyc(1); addr_i = 17'h00A03; cyc(8);
    expect_wr(17'h00A02, 8'h3C, "R5 ce first");
    we_n = 1; cyc(8); ce_n = 1; cyc(10);

    // R5: write strobe first, chip select last
    addr_i = 17'h1B001; data_i = 8'hC3; we_n = 0; cyc(8);
    addr_i = 17'h1B002; cyc(8);
    ce_n = 0; cyc(8); addr_i = 17'h1B003; cyc(8);
    expect_wr(17'h1B002, 8'hC3, "R5 we first");
    ce_n = 1; cyc(8); we_n = 1; cyc(10);

    // R6: write strobe rises first, data changes afterwards
    addr_i = 17'h04000; data_i = 8'hA1; ce_n = 0; cyc(6); we_n = 0; cyc(8);
    expect_wr(17'h04000, 8'hA1, "R6 we rises first");
    we_n = 1; cyc(8); data_i = 8'hA2; cyc(8); ce_n = 1; cyc(10);

    // R6: chip select rises first, data changes afterwards
    addr_i = 17'h08000; data_i = 8'hB1; we_n = 0; cyc(6); ce_n = 0; cyc(8);
    expect_wr(17'h08000, 8'hB1, "R6 ce rises first");
    ce_n = 1; cyc(8); data_i = 8'hB2; cyc(8); we_n = 1; cyc(10);
    check("R7 events so far", evt_seen, 4);

    // R8: two-cycle write strobe glitch during chip select
    addr_i = 17'h0C000; data_i = 8'h11; ce_n = 0; cyc(8);
    we_n = 0; cyc(2); we_n = 1; cyc(10); ce_n = 1; cyc(10);
    // R8: two-cycle chip select glitch with write strobe held low
    we_n = 0; cyc(8); ce_n = 0; cyc(2); ce_n = 1; cyc(10); we_n = 1; cyc(10);
    check("R8 glitches ignored", evt_seen, 4);

    // R9: read strobe dips low inside a write
    addr_i = 17'h10000; data_i = 8'h22; ce_n = 0; cyc(6); we_n = 0; cyc(8);
    oe_n = 0; cyc(10); @(negedge clk);
    check("R2 clash code", cycle_o, 4);
    check("R3 no drive in clash", dout_en_o, 0);
    cyc(1); oe_n = 1; cyc(8); we_n = 1; cyc(8); ce_n = 1; cyc(10);
    check("R9 write discarded", evt_seen, 4);

    // R7: a final clean write after the discarded one
    addr_i = 17'h1FFFF; data_i = 8'hFF; ce_n = 0; cyc(6); we_n = 0; cyc(8);
    expect_wr(17'h1FFFF, 8'hFF, "R7 after discard");
    we_n = 1; cyc(6); ce_n = 1; cyc(15);

    check("R7 total events", evt_seen, evt_pushed);
    check("R5 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule